// File: doc/BRIEF.md
# Link Error Logger and Resynchronization Controller

This block sits beside a multi-lane serial converter receiver. Detector logic elsewhere in the receiver flags a number of error types, one pulse per cycle. The block gathers those pulses into a sticky status word. From that word it drives an interrupt line through an interrupt mask. It also decides when the link must be brought back to code-group synchronization by pulling the active-low synchronization request (SYNC_N) low.

Two masks control the outputs. The interrupt mask selects which latched errors raise the interrupt. The resync mask selects which error events force the link back to synchronization. A global disable bit overrides the resync mask. Error type 0, the code-group synchronization error, always forces resync: no mask or disable can stop it. Software can also request a resync through a self-clearing command bit.

After the lanes report synchronization again, SYNC_N is released. The release can be held back by a programmable stretch, which counts link clocks in subclass 0 and multiframe (LMFC) ticks in subclasses 1 and 2. A small word-addressed port reads and writes status, masks and control.

Top module: `link_err_reinit`

## Requirements
- R1: After a synchronous reset, SYNC_N and the interrupt are low, status is zero, the control word is zero, the interrupt mask (word 1) reads 0x7F (bit 7, the correctable-ECC type, disabled), and the resync mask (word 2) reads 0x0F (types 0 to 3: code-group, frame alignment, lane alignment, SYSREF/LMFC).
- R2: A pulse on error input bit i sets status bit i (word 0). The bit stays set until it is cleared.
- R3: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a clear and a new event on that bit fall in the same cycle, the bit stays set.
- R4: The interrupt is registered. It goes high one cycle after any status bit whose interrupt-mask bit is set is 1, and low otherwise.
- R5: An event on error bit 0 pulls SYNC_N low on the next edge, whatever the resync mask and the global disable hold. Bit 0 of the resync mask always reads 1, and writes to it are ignored.
- R6: An event on error bit i>0 pulls SYNC_N low only when resync-mask bit i is 1 and the global disable (control bit 1) is 0.
- R7: Writing 1 to control bit 0 requests a resync. The bit reads 1 until SYNC_N has been low for one cycle, then clears itself. Writing 0 has no effect.
- R8: SYNC_N stays low while lanes_synced is low. With a stretch of 0 it rises one edge after lanes_synced is seen high.
- R9: In subclass 0, a stretch value D (control bits 7:4) holds SYNC_N low for D additional clock cycles.
- R10: In subclass 1 or 2, the stretch D is counted in lmfc_tick pulses, so SYNC_N rises on the edge of the D-th tick after the lanes are synced.
- R11: Control bit 8 reads the present SYNC_N level.
- R12: A resync cause, or lanes_synced falling, during a stretch returns SYNC_N to its plain low phase, and the stretch restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 8 | One-cycle error event pulses, bit 0 = code-group sync error |
| lanes_synced | input | 1 | All lanes have reached code-group synchronization |
| lmfc_tick | input | 1 | One-cycle pulse at each multiframe boundary |
| subclass | input | 2 | Link subclass (0, 1 or 2) |
| bus_addr | input | 2 | Word select: 0 status, 1 interrupt mask, 2 resync mask, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the word addressed in the previous cycle |
| irq | output | 1 | Interrupt |
| sync_n | output | 1 | Active-low synchronization request |

## Verification
Error patterns are applied one type at a time under different mask settings. This separates the interrupt path from the resync path, and shows that type 0 bypasses both the resync mask and the global disable. A clear written in the same cycle as a new event on the same bit checks the event-priority rule. The stretch is tried at zero and non-zero values in subclass 0, and with periodic multiframe ticks in subclasses 1 and 2. This shows which time base is counted. Restarting a stretch through a new error and through a lost lane sync covers the return path. A random phase then mixes writes, events and lane sync changes, and every cycle is compared against a behavioural reference.

// File: rtl/link_err_pkg.sv
package link_err_pkg;
  typedef enum logic [1:0] {
    SN_REQ  = 2'd0,
    SN_HOLD = 2'd1,
    SN_UP   = 2'd2
  } syncn_state_t;

  localparam logic [1:0] REG_STATUS    = 2'd0;
  localparam logic [1:0] REG_IRQ_EN    = 2'd1;
  localparam logic [1:0] REG_REINIT_EN = 2'd2;
  localparam logic [1:0] REG_CTRL      = 2'd3;

  localparam int CTRL_SW_BIT   = 0;
  localparam int CTRL_GDIS_BIT = 1;
  localparam int CTRL_DLY_LSB  = 4;
endpackage

// File: rtl/lerr_status_log.sv
module lerr_status_log #(
  parameter int NUM_ERR = 8,
  parameter logic [NUM_ERR-1:0] IRQ_EN_RST    = 8'h7F,
  parameter logic [NUM_ERR-1:0] REINIT_EN_RST = 8'h0F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               wr_status,
  input  logic               wr_irq_en,
  input  logic               wr_reinit_en,
  input  logic [NUM_ERR-1:0] wdata,
  output logic [NUM_ERR-1:0] status_q,
  output logic [NUM_ERR-1:0] irq_en_q,
  output logic [NUM_ERR-1:0] reinit_en,
  output logic               irq
);
  localparam logic [NUM_ERR-1:0] CG_ONLY = NUM_ERR'(1);

  logic [NUM_ERR-1:0] clr_mask;
  logic [NUM_ERR-1:0] reinit_q;

  assign clr_mask  = wr_status ? wdata : '0;
  assign reinit_en = reinit_q | CG_ONLY;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)             bit_q <= 1'b0;
      else if (err_evt[i]) bit_q <= 1'b1;
      else if (clr_mask[i]) bit_q <= 1'b0;
    end
    assign status_q[i] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q <= IRQ_EN_RST;
      reinit_q <= REINIT_EN_RST & ~CG_ONLY;
      irq      <= 1'b0;
    end else begin
      if (wr_irq_en)    irq_en_q <= wdata;
      if (wr_reinit_en) reinit_q <= wdata & ~CG_ONLY;
      irq <= |(status_q & irq_en_q);
    end
  end

  // R2
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |=> ((status_q & $past(err_evt)) == $past(err_evt)));
  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & irq_en_q)) |=> !irq);
endmodule

// File: rtl/lerr_syncn_fsm.sv
module lerr_syncn_fsm
  import link_err_pkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int SUBCLASS_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reinit_req,
  input  logic                  lanes_synced,
  input  logic                  lmfc_tick,
  input  logic [SUBCLASS_W-1:0] subclass,
  input  logic [DLY_W-1:0]      stretch,
  output logic                  sync_n,
  output logic                  in_req
);
  syncn_state_t     state_q;
  logic [DLY_W-1:0] cnt_q;
  logic             step;

  assign step   = (subclass == '0) ? 1'b1 : lmfc_tick;
  assign in_req = (state_q == SN_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SN_REQ;
      cnt_q   <= '0;
      sync_n  <= 1'b0;
    end else begin
      case (state_q)
        SN_REQ: begin
          if (!reinit_req && lanes_synced) begin
            if (stretch == '0) begin
              state_q <= SN_UP;
              sync_n  <= 1'b1;
            end else begin
              state_q <= SN_HOLD;
              cnt_q   <= stretch;
            end
          end
        end
        SN_HOLD: begin
          if (reinit_req || !lanes_synced) begin
            state_q <= SN_REQ;
          end else if (step) begin
            if (cnt_q == DLY_W'(1)) begin
              state_q <= SN_UP;
              sync_n  <= 1'b1;
            end
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SN_UP: begin
          if (reinit_req) begin
            state_q <= SN_REQ;
            sync_n  <= 1'b0;
          end
        end
        default: begin
          state_q <= SN_REQ;
          sync_n  <= 1'b0;
        end
      endcase
    end
  end

  // R8
  release_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> $past(lanes_synced));
  // R12
  hold_count_live_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SN_HOLD) |-> (cnt_q != '0));
endmodule

// File: rtl/link_err_reinit.sv
module link_err_reinit
  import link_err_pkg::*;
#(
  parameter int NUM_ERR    = 8,
  parameter int DATA_W     = 32,
  parameter int DLY_W      = 4,
  parameter int SUBCLASS_W = 2,
  parameter logic [NUM_ERR-1:0] IRQ_EN_RST    = 8'h7F,
  parameter logic [NUM_ERR-1:0] REINIT_EN_RST = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_ERR-1:0]    err_evt,
  input  logic                  lanes_synced,
  input  logic                  lmfc_tick,
  input  logic [SUBCLASS_W-1:0] subclass,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq,
  output logic                  sync_n
);
  localparam int SN_BIT = CTRL_DLY_LSB + DLY_W;
  localparam logic [NUM_ERR-1:0] CG_ONLY = NUM_ERR'(1);

  logic [NUM_ERR-1:0] status_q, irq_en_q, reinit_en, eff_mask;
  logic [DLY_W-1:0]   dly_q;
  logic               gdis_q, sw_req_q, in_req, reinit_req, wr_ctrl;
  logic [DATA_W-1:0]  rd_next;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_ctrl      = bus_wr && (bus_addr == REG_CTRL);
  assign eff_mask     = gdis_q ? CG_ONLY : reinit_en;
  assign reinit_req   = (|(err_evt & eff_mask)) || sw_req_q;

  lerr_status_log #(
    .NUM_ERR(NUM_ERR), .IRQ_EN_RST(IRQ_EN_RST), .REINIT_EN_RST(REINIT_EN_RST)
  ) u_log (
    .clk(clk), .rst(rst), .err_evt(err_evt),
    .wr_status(bus_wr && (bus_addr == REG_STATUS)),
    .wr_irq_en(bus_wr && (bus_addr == REG_IRQ_EN)),
    .wr_reinit_en(bus_wr && (bus_addr == REG_REINIT_EN)),
    .wdata(bus_wdata[NUM_ERR-1:0]),
    .status_q(status_q), .irq_en_q(irq_en_q), .reinit_en(reinit_en), .irq(irq)
  );

  lerr_syncn_fsm #(.DLY_W(DLY_W), .SUBCLASS_W(SUBCLASS_W)) u_fsm (
    .clk(clk), .rst(rst), .reinit_req(reinit_req), .lanes_synced(lanes_synced),
    .lmfc_tick(lmfc_tick), .subclass(subclass), .stretch(dly_q),
    .sync_n(sync_n), .in_req(in_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gdis_q   <= 1'b0;
      dly_q    <= '0;
      sw_req_q <= 1'b0;
    end else begin
      sw_req_q <= (sw_req_q && !in_req) || (wr_ctrl && bus_wdata[CTRL_SW_BIT]);
      if (wr_ctrl) begin
        gdis_q <= bus_wdata[CTRL_GDIS_BIT];
        dly_q  <= bus_wdata[CTRL_DLY_LSB +: DLY_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      REG_STATUS:    rd_next[NUM_ERR-1:0] = status_q;
      REG_IRQ_EN:    rd_next[NUM_ERR-1:0] = irq_en_q;
      REG_REINIT_EN: rd_next[NUM_ERR-1:0] = reinit_en;
      default: begin
        rd_next[CTRL_SW_BIT]               = sw_req_q;
        rd_next[CTRL_GDIS_BIT]             = gdis_q;
        rd_next[CTRL_DLY_LSB +: DLY_W]     = dly_q;
        rd_next[SN_BIT]                    = sync_n;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R5
  cg_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt[0] |=> !sync_n);
  // R7
  sw_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_req_q && sync_n) |=> !sync_n);
  // R6
  gdis_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_n && gdis_q && !err_evt[0] && !sw_req_q) |=> sync_n);
endmodule

// File: tb/link_err_reinit_test.sv
module link_err_reinit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  err_evt = '0;
  logic        lanes_synced = 1'b0;
  logic        lmfc_tick = 1'b0;
  logic [1:0]  subclass = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sync_n;

  int    n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  string tag = "R1";
  bit    tick_en = 1'b0;
  int    tick_ph = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  link_err_reinit uut (
    .clk(clk), .rst(rst), .err_evt(err_evt), .lanes_synced(lanes_synced),
    .lmfc_tick(lmfc_tick), .subclass(subclass), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sync_n(sync_n)
  );

  // behavioural reference
  logic [7:0]  m_status, m_ien, m_rien, eff;
  logic [3:0]  m_dly;
  logic        m_gdis, m_sw, trg, step;
  int          m_mode, m_cnt;
  logic [31:0] e_rdata;
  logic        e_irq, e_syncn;

  always @(posedge clk) begin
    if (rst) begin
      m_status = 0; m_ien = 8'h7F; m_rien = 8'h0F; m_dly = 0; m_gdis = 0;
      m_sw = 0; m_mode = 0; m_cnt = 0; e_rdata = 0; e_irq = 0; e_syncn = 0;
    end else begin
      case (bus_addr)
        2'd0: e_rdata = {24'd0, m_status};
        2'd1: e_rdata = {24'd0, m_ien};
        2'd2: e_rdata = {24'd0, m_rien | 8'h01};
        default: e_rdata = {23'd0, e_syncn, m_dly, 2'b00, m_gdis, m_sw};
      endcase
      e_irq = (m_status & m_ien) != 0;
      eff   = m_gdis ? 8'h01 : (m_rien | 8'h01);
      trg   = ((err_evt & eff) != 0) || m_sw;
      step  = (subclass == 0) || lmfc_tick;
      m_sw  = (m_sw && m_mode != 0) || (bus_wr && bus_addr == 3 && bus_wdata[0]);
      if (m_mode == 0) begin
        if (!trg && lanes_synced) begin
          if (m_dly == 0) begin m_mode = 2; e_syncn = 1; end
          else begin m_mode = 1; m_cnt = m_dly; end
        end
      end else if (m_mode == 1) begin
        if (trg || !lanes_synced) m_mode = 0;
        else if (step) begin
          if (m_cnt == 1) begin m_mode = 2; e_syncn = 1; end
          m_cnt = m_cnt - 1;
        end
      end else if (trg) begin
        m_mode = 0; e_syncn = 0;
      end
      if (bus_wr && bus_addr == 0) m_status = m_status & ~bus_wdata[7:0];
      m_status = m_status | err_evt;
      if (bus_wr && bus_addr == 1) m_ien = bus_wdata[7:0];
      if (bus_wr && bus_addr == 2) m_rien = bus_wdata[7:0] & 8'hFE;
      if (bus_wr && bus_addr == 3) begin m_gdis = bus_wdata[1]; m_dly = bus_wdata[7:4]; end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp += 3;
      if (bus_rdata !== e_rdata) begin
        n_bad++; $display("FAIL %s rdata actual %h expected %h t=%0t", tag, bus_rdata, e_rdata, $time);
      end
      if (irq !== e_irq) begin
        n_bad++; $display("FAIL %s irq actual %b expected %b t=%0t", tag, irq, e_irq, $time);
      end
      if (sync_n !== e_syncn) begin
        n_bad++; $display("FAIL %s sync_n actual %b expected %b t=%0t", tag, sync_n, e_syncn, $time);
      end
      tick_ph++;
      lmfc_tick <= tick_en && (tick_ph % 4 == 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [1:0] a);
    bus_addr = a; cyc(2);
  endtask
  task automatic pulse(logic [7:0] m);
    err_evt = m; @(negedge clk); err_evt = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_bad++; $display("FAIL watchdog expired"); finish_run();
    end
  end

  initial begin
    tag = "R1"; cyc(3); rst = 1'b0;
    rd(0); rd(1); rd(2); rd(3);
    tag = "R8"; cyc(4); lanes_synced = 1'b1; rd(3); cyc(2);
    tag = "R2"; pulse(8'h10); rd(0); pulse(8'h80); rd(0); cyc(3);
    tag = "R4"; rd(1); cyc(2); wr(1, 32'hFF); cyc(2);
    tag = "R3"; bus_addr = 0; bus_wr = 1; bus_wdata = 32'h10; err_evt = 8'h10;
    @(negedge clk); bus_wr = 0; err_evt = 0; rd(0);
    wr(0, 32'h00); rd(0); wr(0, 32'hFF); rd(0); cyc(2);
    tag = "R6"; pulse(8'h10); cyc(3); pulse(8'h02); cyc(3);
    wr(3, 32'h2); pulse(8'h02); pulse(8'h0E); cyc(3);
    tag = "R5"; wr(2, 32'h0); rd(2); pulse(8'h01); cyc(3); wr(2, 32'h01); rd(2);
    tag = "R7"; wr(3, 32'h3); rd(3); rd(3); wr(3, 32'h2); rd(3); cyc(2);
    tag = "R11"; rd(3); pulse(8'h01); bus_addr = 3; cyc(1); cyc(3);
    tag = "R9"; wr(3, 32'h50); pulse(8'h01); cyc(10); wr(3, 32'hF0); pulse(8'h01); cyc(20);
    tag = "R10"; subclass = 2'd1; tick_en = 1'b1; wr(3, 32'h30); pulse(8'h01); cyc(25);
    subclass = 2'd2; wr(3, 32'h20); pulse(8'h01); cyc(15);
    tag = "R12"; wr(3, 32'h40); pulse(8'h01); cyc(6); pulse(8'h01); cyc(6);
    lanes_synced = 1'b0; cyc(3); lanes_synced = 1'b1; cyc(25);
    subclass = 2'd0; tick_en = 1'b0; wr(3, 32'h30); pulse(8'h01); cyc(2); pulse(8'h04); cyc(8);
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      err_evt = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      bus_addr = 2'($urandom);
      bus_wr = (($urandom % 5) == 0);
      bus_wdata = $urandom & 32'h0000_00F3;
      if (($urandom % 40) == 0) lanes_synced = ~lanes_synced;
      subclass = 2'($urandom % 3);
      tick_en = 1'b1;
      @(negedge clk);
    end
    err_evt = 0; bus_wr = 0; cyc(3);
    finish_run();
  end
endmodule